// File: doc/BRIEF.md
# Halfword and Byte Swap Unit

This unit is a datapath slice for a 64-bit integer pipeline. It takes a 64-bit source operand and the fields of the instruction (major opcode, source register field, shift-amount field and function field). From these it computes one of five results: a byte swap inside every 16-bit halfword of the doubleword, a byte swap inside the two halfwords of the low word with the 32-bit result sign-extended to 64 bits, a reversal of the four halfwords of the doubleword, a byte sign extension, or a halfword sign extension.

The result leaves through an output register, so it appears one clock after a request. A valid strobe marks a good result. Two separate flag strobes mark an encoding that names none of the five operations, and a doubleword operation issued while 64-bit operations are disabled. The surrounding pipeline owns register-file access, hazards and the raising of the actual exception. This unit only reports the condition.

Top module: `hbs_unit`

## Requirements
- R1: The doubleword byte swap returns, for each halfword k (0..3), result[16k+15:16k] = {src[16k+7:16k], src[16k+15:16k+8]}.
- R2: The word byte swap returns result[31:0] = {src[23:16], src[31:24], src[7:0], src[15:8]}. result[63:32] are all copies of result[31], which is the swapped value and not src[31].
- R3: The halfword reversal returns src[63:48] in result[15:0], src[47:32] in result[31:16], src[31:16] in result[47:32] and src[15:0] in result[63:48].
- R4: The byte sign extension returns src[7:0] in result[7:0], with result[63:8] all equal to src[7].
- R5: The halfword sign extension returns src[15:0] in result[15:0], with result[63:16] all equal to src[15].
- R6: An operation is recognised only when the opcode is 6'b011111 and the rs field is 5'b00000. With function 6'b100100, shamt 5'b00010 selects the doubleword byte swap and 5'b00101 selects the halfword reversal. With function 6'b100000, shamt 5'b00010 selects the word byte swap, 5'b10000 the byte sign extension and 5'b11000 the halfword sign extension.
- R7: A doubleword byte swap or halfword reversal requested while en64_i is low raises rsvd_o for one cycle. out_valid_o stays low and result_o keeps its previous value.
- R8: A request that R6 does not recognise raises illop_o for one cycle. out_valid_o stays low and result_o keeps its previous value.
- R9: result_o and the strobes change on the rising clock edge after a request. In a cycle after one with req_valid_i low, every strobe is low and result_o is unchanged.
- R10: While rst_n is low, result_o is zero and all strobes are low. The reset takes effect without a clock edge.
- R11: At most one of out_valid_o, illop_o and rsvd_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| en64_i | input | 1 | 64-bit operations enabled |
| opcode_i | input | 6 | Major opcode field |
| rs_i | input | 5 | rs field, must be zero |
| shamt_i | input | 5 | Shift-amount field, selects the operation |
| funct_i | input | 6 | Function field |
| src_i | input | 64 | Source operand |
| result_o | output | 64 | Registered result |
| out_valid_o | output | 1 | result_o was updated by a legal request |
| illop_o | output | 1 | Unrecognised encoding |
| rsvd_o | output | 1 | Doubleword operation with 64-bit operations disabled |

## Verification
A wrong lane in the swap network shows up in result_o one cycle after the request. It appears as a byte or halfword in the wrong place, or as a wrong fill in the upper word. Two source patterns have opposite sign bits, and an extra word operand carries its sign bit only after the swap. Together they expose a fill taken from the wrong bit. A decode fault shows up in that same cycle as the wrong strobe: a missing valid, a flag that should not fire, or a held result that moves. A register that fails to clear or to hold is caught by the reset check and by the idle-cycle check.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [2:0] {
    HOP_NONE  = 3'd0,
    HOP_DSWAP = 3'd1,
    HOP_HREV  = 3'd2,
    HOP_WSWAP = 3'd3,
    HOP_SEXTB = 3'd4,
    HOP_SEXTH = 3'd5
  } hop_e;

  localparam logic [5:0] OPC_SPECIAL3 = 6'b011111;
  localparam logic [5:0] FN_DBL       = 6'b100100;
  localparam logic [5:0] FN_WRD       = 6'b100000;
  localparam logic [4:0] SA_BSWAP     = 5'b00010;
  localparam logic [4:0] SA_HREV      = 5'b00101;
  localparam logic [4:0] SA_SEXTB     = 5'b10000;
  localparam logic [4:0] SA_SEXTH     = 5'b11000;
endpackage

// File: rtl/hbs_decode.sv
module hbs_decode
  import hbs_pkg::*;
(
  input  logic       en64_i,
  input  logic [5:0] opcode_i,
  input  logic [4:0] rs_i,
  input  logic [4:0] shamt_i,
  input  logic [5:0] funct_i,
  output hop_e       op_o,
  output logic       illegal_o,
  output logic       reserved_o
);
  logic base_ok;
  logic is_dbl;

  always_comb begin
    base_ok = (opcode_i == OPC_SPECIAL3) && (rs_i == 5'd0);
    op_o    = HOP_NONE;
    if (base_ok) begin
      if (funct_i == FN_DBL) begin
        if (shamt_i == SA_BSWAP)     op_o = HOP_DSWAP;
        else if (shamt_i == SA_HREV) op_o = HOP_HREV;
      end else if (funct_i == FN_WRD) begin
        if (shamt_i == SA_BSWAP)      op_o = HOP_WSWAP;
        else if (shamt_i == SA_SEXTB) op_o = HOP_SEXTB;
        else if (shamt_i == SA_SEXTH) op_o = HOP_SEXTH;
      end
    end
    is_dbl     = (op_o == HOP_DSWAP) || (op_o == HOP_HREV);
    illegal_o  = (op_o == HOP_NONE);
    reserved_o = is_dbl && !en64_i;
  end
endmodule

// File: rtl/hbs_datapath.sv
module hbs_datapath
  import hbs_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned HW = HALF_W
) (
  input  hop_e          op_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned NHALF = DW / HW;
  localparam int unsigned BW    = HW / 2;
  localparam int unsigned WW    = DW / 2;
  localparam int unsigned NWH   = WW / HW;

  logic [DW-1:0] bswap_all;
  logic [DW-1:0] hrev;
  logic [WW-1:0] wswap_lo;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign bswap_all[h*HW +: HW] = {src_i[h*HW +: BW], src_i[h*HW+BW +: BW]};
    assign hrev[h*HW +: HW]      = src_i[(NHALF-1-h)*HW +: HW];
  end

  for (genvar w = 0; w < NWH; w++) begin : g_wlane
    assign wswap_lo[w*HW +: HW] = bswap_all[w*HW +: HW];
  end

  always_comb begin
    unique case (op_i)
      HOP_DSWAP: res_o = bswap_all;
      HOP_HREV:  res_o = hrev;
      HOP_WSWAP: res_o = {{(DW-WW){wswap_lo[WW-1]}}, wswap_lo};
      HOP_SEXTB: res_o = {{(DW-BW){src_i[BW-1]}}, src_i[BW-1:0]};
      HOP_SEXTH: res_o = {{(DW-HW){src_i[HW-1]}}, src_i[HW-1:0]};
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/hbs_outreg.sv
module hbs_outreg #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          illegal_i,
  input  logic          reserved_i,
  input  logic [DW-1:0] res_i,
  output logic [DW-1:0] result_o,
  output logic          valid_o,
  output logic          illop_o,
  output logic          rsvd_o
);
  logic          load_en;
  logic          valid_d, illop_d, rsvd_d;
  logic [DW-1:0] result_d;

  always_comb begin
    load_en  = req_i && !illegal_i && !reserved_i;
    valid_d  = load_en;
    illop_d  = req_i && illegal_i;
    rsvd_d   = req_i && !illegal_i && reserved_i;
    result_d = load_en ? res_i : result_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      illop_o  <= 1'b0;
      rsvd_o   <= 1'b0;
    end else begin
      result_o <= result_d;
      valid_o  <= valid_d;
      illop_o  <= illop_d;
      rsvd_o   <= rsvd_d;
    end
  end
endmodule

// File: rtl/hbs_unit.sv
module hbs_unit
  import hbs_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic          en64_i,
  input  logic [5:0]    opcode_i,
  input  logic [4:0]    rs_i,
  input  logic [4:0]    shamt_i,
  input  logic [5:0]    funct_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] result_o,
  output logic          out_valid_o,
  output logic          illop_o,
  output logic          rsvd_o
);
  hop_e          op;
  logic          illegal, reserved;
  logic [DW-1:0] res_c;

  hbs_decode u_dec (
    .en64_i    (en64_i),
    .opcode_i  (opcode_i),
    .rs_i      (rs_i),
    .shamt_i   (shamt_i),
    .funct_i   (funct_i),
    .op_o      (op),
    .illegal_o (illegal),
    .reserved_o(reserved)
  );

  hbs_datapath #(.DW(DW), .HW(HW)) u_dp (
    .op_i (op),
    .src_i(src_i),
    .res_o(res_c)
  );

  hbs_outreg #(.DW(DW)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_valid_i),
    .illegal_i (illegal),
    .reserved_i(reserved),
    .res_i     (res_c),
    .result_o  (result_o),
    .valid_o   (out_valid_o),
    .illop_o   (illop_o),
    .rsvd_o    (rsvd_o)
  );
endmodule

// File: rtl/hbs_unit_chk.sv
module hbs_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic        en64_i,
  input logic [5:0]  opcode_i,
  input logic [4:0]  rs_i,
  input logic [4:0]  shamt_i,
  input logic [5:0]  funct_i,
  input logic [63:0] src_i,
  input logic [63:0] result_o,
  input logic        out_valid_o,
  input logic        illop_o,
  input logic        rsvd_o
);
  logic hdr_ok, req_dbl, req_wsw, req_sb;
  assign hdr_ok  = req_valid_i && opcode_i == 6'b011111 && rs_i == 5'd0;
  assign req_dbl = hdr_ok && funct_i == 6'b100100 &&
                   (shamt_i == 5'b00010 || shamt_i == 5'b00101);
  assign req_wsw = hdr_ok && funct_i == 6'b100000 && shamt_i == 5'b00010;
  assign req_sb  = hdr_ok && funct_i == 6'b100000 && shamt_i == 5'b10000;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid_o, illop_o, rsvd_o})); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !out_valid_o && !illop_o && !rsvd_o && $stable(result_o)); // R9

  AST_DBL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    req_dbl && !en64_i |=> rsvd_o && !out_valid_o && $stable(result_o)); // R7

  AST_WORD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    req_wsw |=> out_valid_o && result_o[63:32] == {32{result_o[31]}}); // R2

  AST_BYTE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    req_sb |=> out_valid_o && result_o[63:8] == {56{$past(src_i[7])}}); // R4

  AST_NO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i && opcode_i != 6'b011111 |=> illop_o && $stable(result_o)); // R8
endmodule

bind hbs_unit hbs_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .en64_i(en64_i),
  .opcode_i(opcode_i), .rs_i(rs_i), .shamt_i(shamt_i), .funct_i(funct_i),
  .src_i(src_i), .result_o(result_o), .out_valid_o(out_valid_o),
  .illop_o(illop_o), .rsvd_o(rsvd_o)
);

// File: tb/hbs_unit_tb.sv
module hbs_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i, en64_i;
  logic [5:0]  opcode_i, funct_i;
  logic [4:0]  rs_i, shamt_i;
  logic [63:0] src_i, result_o;
  logic        out_valid_o, illop_o, rsvd_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  hbs_unit u_dut (.*);

  localparam logic [5:0] FD = 6'b100100;
  localparam logic [5:0] FW = 6'b100000;
  localparam int NV = 17;
  // {shamt, funct, src, expected}
  localparam logic [138:0] VEC [NV] = '{
    {5'b00010, FD, 64'h0123_4567_89AB_CDEF, 64'h2301_6745_AB89_EFCD}, // R1
    {5'b00010, FD, 64'hFEDC_BA98_7654_3210, 64'hDCFE_98BA_5476_1032}, // R1
    {5'b00101, FD, 64'h0123_4567_89AB_CDEF, 64'hCDEF_89AB_4567_0123}, // R3
    {5'b00101, FD, 64'hFEDC_BA98_7654_3210, 64'h3210_7654_BA98_FEDC}, // R3
    {5'b00010, FW, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_AB89_EFCD}, // R2
    {5'b00010, FW, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_5476_1032}, // R2
    {5'b00010, FW, 64'h0000_0000_00FF_0000, 64'hFFFF_FFFF_FF00_0000}, // R2 sign after swap
    {5'b00010, FW, 64'h1234_5678_0000_7F80, 64'h0000_0000_0000_807F}, // R2
    {5'b10000, FW, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFEF}, // R4
    {5'b10000, FW, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_0010}, // R4
    {5'b10000, FW, 64'h1234_5678_0000_7F80, 64'hFFFF_FFFF_FFFF_FF80}, // R4
    {5'b10000, FW, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0000_0000_0000_007F}, // R4
    {5'b11000, FW, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_CDEF}, // R5
    {5'b11000, FW, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_3210}, // R5
    {5'b11000, FW, 64'h1234_5678_0000_7F80, 64'h0000_0000_0000_7F80}, // R5
    {5'b11000, FW, 64'h0000_0000_0000_8000, 64'hFFFF_FFFF_FFFF_8000}, // R5
    {5'b00010, FD, 64'h00FF_FF00_0080_8000, 64'hFF00_00FF_8000_0080}  // R1
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic flags(input string req, input logic v, input logic i, input logic r);
    chk(req, {61'd0, out_valid_o, illop_o, rsvd_o}, {61'd0, v, i, r});
  endtask

  // drive at negedge, sample 1 time unit after the next rising edge
  task automatic issue(input logic [5:0] opc, input logic [4:0] rs,
                       input logic [4:0] sa, input logic [5:0] fn, input logic [63:0] s);
    @(negedge clk);
    req_valid_i = 1'b1; opcode_i = opc; rs_i = rs; shamt_i = sa; funct_i = fn; src_i = s;
    @(posedge clk);
    #1;
    req_valid_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; req_valid_i = 1'b0; en64_i = 1'b1;
    opcode_i = 6'b011111; rs_i = '0; shamt_i = '0; funct_i = '0; src_i = '0;
    #23;
    chk("R10 reset result", result_o, 64'd0);
    flags("R10 reset strobes", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      issue(6'b011111, 5'd0, VEC[k][138:134], VEC[k][133:128], VEC[k][127:64]);
      chk("R1-5 vector result (R6 decode)", result_o, VEC[k][63:0]);
      flags("R6 valid strobe", 1'b1, 1'b0, 1'b0);
    end

    held = result_o;
    // R9 idle cycle
    @(negedge clk); src_i = 64'hDEAD_BEEF_0000_1111;
    @(posedge clk); #1;
    chk("R9 idle hold", result_o, held);
    flags("R9 idle strobes", 1'b0, 1'b0, 1'b0);

    // R7 doubleword ops with 64-bit disabled
    en64_i = 1'b0;
    issue(6'b011111, 5'd0, 5'b00010, FD, 64'h1111_2222_3333_4444);
    chk("R7 dswap held", result_o, held);
    flags("R7 dswap flag", 1'b0, 1'b0, 1'b1);
    issue(6'b011111, 5'd0, 5'b00101, FD, 64'h1111_2222_3333_4444);
    chk("R7 hrev held", result_o, held);
    flags("R7 hrev flag", 1'b0, 1'b0, 1'b1);
    issue(6'b011111, 5'd0, 5'b00010, FW, 64'h0000_0000_1234_5678);
    chk("R7 word op allowed", result_o, 64'h0000_0000_3412_7856);
    flags("R7 word op valid", 1'b1, 1'b0, 1'b0);
    en64_i = 1'b1;
    held = result_o;

    // R8 unrecognised encodings
    issue(6'b011111, 5'd0, 5'b00011, FD, 64'hAAAA_5555_AAAA_5555);
    chk("R8 bad shamt held", result_o, held);
    flags("R8 bad shamt flag", 1'b0, 1'b1, 1'b0);
    issue(6'b011110, 5'd0, 5'b00010, FD, 64'hAAAA_5555_AAAA_5555);
    chk("R8 bad opcode held", result_o, held);
    flags("R8 bad opcode flag", 1'b0, 1'b1, 1'b0);
    issue(6'b011111, 5'd1, 5'b10000, FW, 64'hAAAA_5555_AAAA_5555);
    chk("R8 rs nonzero held", result_o, held);
    flags("R8 rs nonzero flag", 1'b0, 1'b1, 1'b0);
    en64_i = 1'b0;
    issue(6'b011111, 5'd0, 5'b00101, FW, 64'hAAAA_5555_AAAA_5555);
    flags("R8 R11 bad funct single flag", 1'b0, 1'b1, 1'b0);
    en64_i = 1'b1;

    // R10 asynchronous reset mid-run
    issue(6'b011111, 5'd0, 5'b00101, FD, 64'h0123_4567_89AB_CDEF);
    chk("R3 before reset", result_o, 64'hCDEF_89AB_4567_0123);
    #2 rst_n = 1'b0;
    #1;
    chk("R10 async clear result", result_o, 64'd0);
    flags("R10 async clear strobes", 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule